// File: doc/BRIEF.md
# Command-Style Flow Control Register

This block is a single 32-bit control register for a MAC's flow control configuration, reached through a plain write strobe with a data word and a combinational readback word. The upper command byte is never written directly. Each write carries one value bit at position 23 and a bitmap in positions 22:16. Every bitmap position written as 1 takes the value bit, and every other position keeps its state. Software can therefore set or clear any single control bit atomically, with no read-modify-write. The low half-word holds a pause length that each write loads directly.

The stored control bits are: force-pause (bit 20), negotiate-pause (bit 19), fixed-length pause selection (bit 18), flow-control pin enable (bit 17) and a flow-control command bit (bit 16). The block resolves these bits, together with the link partner's auto-negotiated pause capability, into a registered pause-enable output. Hardware reset clears the register. So does a strobe from the configuration loader at the start of a serial EEPROM load, or when that load reports an error.

Top module: `flowctl_cmd_reg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, rd_data reads 0x00000000, pause_enable is 0 and every field output is 0.
- R2: On a write, each implemented bitmap position (bits 20:16 of wr_data) that is 1 loads wr_data bit 23 into the register bit at the same position. The new value is visible on rd_data and on the field outputs after that clock edge.
- R3: On a write, each register bit in 20:16 whose bitmap position is 0 keeps its previous value.
- R4: Every write loads wr_data[15:0] directly into the pause length field, which is returned on rd_data[15:0] and on pause_len.
- R5: rd_data bits 31:21 always read 0, whatever is written there. Bitmap positions 22:21 store nothing.
- R6: A one-cycle load_start strobe clears the whole register at the next clock edge.
- R7: A one-cycle load_error strobe clears the whole register at the next clock edge.
- R8: When a write and a clear strobe arrive in the same cycle, the clear wins and the register reads 0.
- R9: pause_enable equals force OR (negotiate AND partner_pause_ok), taken from the register and partner input one clock edge earlier.
- R10: With the force bit set, pause_enable is 1 whatever partner_pause_ok is. With force clear and negotiate set, pause_enable follows partner_pause_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: value bit 23, bitmap 22:16, pause length 15:0 |
| rd_data | output | 32 | Readback word, reserved bits as zero |
| load_start | input | 1 | Strobe: serial EEPROM load begins |
| load_error | input | 1 | Strobe: serial EEPROM load failed |
| partner_pause_ok | input | 1 | Auto-negotiation reports partner supports pause |
| pause_enable | output | 1 | Resolved, registered pause ability |
| force_pause | output | 1 | Stored force-pause bit |
| negotiate_pause | output | 1 | Stored negotiate-pause bit |
| fixed_len_pause | output | 1 | Stored fixed-length pause selection |
| fc_pin_en | output | 1 | Stored flow-control pin enable |
| fc_cmd | output | 1 | Stored flow-control command bit |
| pause_len | output | 16 | Stored pause length operand |

## Verification
The bench writes with a value of 0 into a bitmap position whose bit is already 0, and with a value of 1 into the reserved bitmap positions. A design that treated the bitmap as data, or that let reserved positions store, would show stray bits on readback. It sends a write in the same cycle as a load error strobe, which catches a design that gives the bus priority over the clear. It also times pause_enable against changes in the register and in the partner input, and toggles the partner input while force is set. A combinational or two-stage resolver, or one that lets negotiate override force, would then miss a check.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
    localparam int REG_W      = 32;
    localparam int LEN_W      = 16;
    localparam int MAP_LSB    = 16;
    localparam int MAP_W      = 7;
    localparam int VAL_POS    = MAP_LSB + MAP_W;
    // implemented control bits inside the bitmap (positions 16..20)
    localparam logic [MAP_W-1:0] IMPL_MASK = 7'b001_1111;
    localparam int POS_CMD    = 0;
    localparam int POS_PINEN  = 1;
    localparam int POS_FIXED  = 2;
    localparam int POS_NEG    = 3;
    localparam int POS_FORCE  = 4;

    typedef struct packed {
        logic [MAP_W-1:0] ctl;
        logic [LEN_W-1:0] len;
    } flow_state_t;

    function automatic logic [REG_W-1:0] pack_readback(input flow_state_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[MAP_LSB +: MAP_W] = s.ctl & IMPL_MASK;
        w[LEN_W-1:0]        = s.len;
        return w;
    endfunction
endpackage

// File: rtl/flowctl_mask_write.sv
module flowctl_mask_write #(
    parameter int               W    = 7,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] map,
    input  logic         val,
    output logic [W-1:0] nxt
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            assign nxt[i] = map[i] ? val : cur[i];
        end else begin : g_rsvd
            assign nxt[i] = 1'b0;
        end
    end
endmodule

// File: rtl/flowctl_pause_resolve.sv
module flowctl_pause_resolve (
    input  logic clk,
    input  logic rst_n,
    input  logic force_bit,
    input  logic neg_bit,
    input  logic partner_ok,
    output logic pause_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pause_en <= 1'b0;
        else        pause_en <= force_bit | (neg_bit & partner_ok);
    end

    // R9
    pause_tracks_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_en == ($past(force_bit) | ($past(neg_bit) & $past(partner_ok))));
    // R10
    force_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_bit |=> pause_en);
endmodule

// File: rtl/flowctl_cmd_reg.sv
module flowctl_cmd_reg
    import flowctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             load_start,
    input  logic             load_error,
    input  logic             partner_pause_ok,
    output logic             pause_enable,
    output logic             force_pause,
    output logic             negotiate_pause,
    output logic             fixed_len_pause,
    output logic             fc_pin_en,
    output logic             fc_cmd,
    output logic [LEN_W-1:0] pause_len
);
    flow_state_t       st;
    logic [MAP_W-1:0]  ctl_nxt;
    logic              clr;

    assign clr = load_start | load_error;

    flowctl_mask_write #(.W(MAP_W), .IMPL(IMPL_MASK)) u_mask (
        .cur (st.ctl),
        .map (wr_data[MAP_LSB +: MAP_W]),
        .val (wr_data[VAL_POS]),
        .nxt (ctl_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else if (clr) begin
            st <= '0;
        end else if (wr_en) begin
            st.ctl <= ctl_nxt;
            st.len <= wr_data[LEN_W-1:0];
        end
    end

    assign rd_data         = pack_readback(st);
    assign force_pause     = st.ctl[POS_FORCE];
    assign negotiate_pause = st.ctl[POS_NEG];
    assign fixed_len_pause = st.ctl[POS_FIXED];
    assign fc_pin_en       = st.ctl[POS_PINEN];
    assign fc_cmd          = st.ctl[POS_CMD];
    assign pause_len       = st.len;

    flowctl_pause_resolve u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_bit  (force_pause),
        .neg_bit    (negotiate_pause),
        .partner_ok (partner_pause_ok),
        .pause_en   (pause_enable)
    );

    // R6 R7 R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == '0));
    // R3
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> ((rd_data[MAP_LSB +: MAP_W] & ~$past(wr_data[MAP_LSB +: MAP_W]))
                          == ($past(rd_data[MAP_LSB +: MAP_W]) & ~$past(wr_data[MAP_LSB +: MAP_W]))));
    // R2
    mapped_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> ((rd_data[MAP_LSB +: MAP_W] & $past(wr_data[MAP_LSB +: MAP_W]) & IMPL_MASK)
                          == ({MAP_W{$past(wr_data[VAL_POS])}} & $past(wr_data[MAP_LSB +: MAP_W]) & IMPL_MASK)));
    // R4
    len_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (pause_len == $past(wr_data[LEN_W-1:0])));
    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[REG_W-1:MAP_LSB+5] == '0));
endmodule

// File: tb/flowctl_cmd_reg_test.sv
module flowctl_cmd_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        load_start = 1'b0;
    logic        load_error = 1'b0;
    logic        partner_pause_ok = 1'b0;
    logic        pause_enable, force_pause, negotiate_pause, fixed_len_pause, fc_pin_en, fc_cmd;
    logic [15:0] pause_len;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flowctl_cmd_reg uut (.*);

    // {wr_data, partner, expected rd_data, expected pause_enable}
    localparam logic [65:0] VEC [0:7] = '{
        {32'h0090_1234, 1'b0, 32'h0010_1234, 1'b1},  // R2 set force, R4 len
        {32'h0008_ABCD, 1'b0, 32'h0010_ABCD, 1'b1},  // R3 clear already-0 bit
        {32'h00BE_0055, 1'b1, 32'h001E_0055, 1'b1},  // R2 multi-set, R5 bit21 ignored
        {32'h0010_0000, 1'b1, 32'h000E_0000, 1'b1},  // R3 clear force, R10 negotiate
        {32'hFF01_0000, 1'b0, 32'h000E_0000, 1'b0},  // R5 reserved top, R10 partner off
        {32'h0081_7777, 1'b0, 32'h000F_7777, 1'b0},  // R2 set cmd
        {32'h0004_0000, 1'b1, 32'h000B_0000, 1'b1},  // R3 clear fixed only
        {32'h00FF_0000, 1'b0, 32'h001F_0000, 1'b1}   // R5/R10 force with partner off
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", rd_data, 32'h0);
        chk("R1", {31'h0, pause_enable}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rd_data, 32'h0);
        chk("R1", {26'h0, pause_enable, force_pause, negotiate_pause, fixed_len_pause, fc_pin_en, fc_cmd}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = VEC[i][65:34]; partner_pause_ok = VEC[i][33];
            @(negedge clk);
            wr_en = 1'b0;
            chk("R2/R3/R4/R5 readback", rd_data, VEC[i][32:1]);
            @(negedge clk);
            chk("R9/R10 pause_enable", {31'h0, pause_enable}, {31'h0, VEC[i][0]});
        end
        chk("R2 field outputs", {27'h0, force_pause, negotiate_pause, fixed_len_pause, fc_pin_en, fc_cmd}, 32'h1F);
        chk("R4 pause_len", {16'h0, pause_len}, 32'h0);

        // R6 load_start clears
        write_word(32'h0001_5A5A);
        @(negedge clk);
        load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
        chk("R6", rd_data, 32'h0);
        @(negedge clk);
        chk("R6 pause_enable", {31'h0, pause_enable}, 32'h0);

        // R7 load_error clears
        write_word(32'h009C_0042);
        chk("R7 precondition", rd_data, 32'h001C_0042);
        @(negedge clk);
        load_error = 1'b1;
        @(negedge clk);
        load_error = 1'b0;
        chk("R7", rd_data, 32'h0);

        // R8 write collides with clear
        write_word(32'h0088_0001);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h00FF_1111; load_error = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; load_error = 1'b0;
        chk("R8", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h00FF_2222; load_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; load_start = 1'b0;
        chk("R8 start", rd_data, 32'h0);

        // R9 timing of partner change with negotiate only
        partner_pause_ok = 1'b0;
        write_word(32'h0088_0000);
        @(negedge clk);
        chk("R9 partner low", {31'h0, pause_enable}, 32'h0);
        partner_pause_ok = 1'b1;
        @(negedge clk);
        chk("R9 one edge later", {31'h0, pause_enable}, 32'h1);
        partner_pause_ok = 1'b0;
        @(negedge clk);
        chk("R9 partner drop", {31'h0, pause_enable}, 32'h0);

        // R10 force ignores partner toggling
        write_word(32'h0090_0000);
        @(negedge clk);
        chk("R10 force partner low", {31'h0, pause_enable}, 32'h1);
        partner_pause_ok = 1'b1;
        @(negedge clk);
        partner_pause_ok = 1'b0;
        @(negedge clk);
        chk("R10 force after toggle", {31'h0, pause_enable}, 32'h1);

        // R5 reserved only writes leave state and read zero
        write_word(32'hFF60_0000);
        chk("R5", rd_data, 32'h0018_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule